// File: doc/BRIEF.md
# Configurable Port Mode Router

This block is the digital control plane for a bank of programmable I/O ports. Each port holds a configuration word with four fields: a mode code, an invert flag, an index naming a partner port, and a range code. From this word the block works out three things for every port: what the port drives as a digital output, whether the output enable is on, and whether the port must be sampled by the converter.

A digital output can take its level from a host-written data bit. It can instead repeat the registered input of any other port, with optional inversion, so one input can feed several outputs at once. Each port also stores a DAC code. A write to that code starts a settling counter, and both digital output modes stay low until the counter has expired. In the monitored-DAC mode with a half-span range code, the stored code is clipped before it leaves the block.

The host writes configuration words, DAC codes and output data through plain write-enable strobes. The analog side reads the clipped codes and the sample flags.

Top module: `port_mode_router`

## Requirements
- R1: While reset is held and directly after it, every port has mode 0, pin_oe and pin_out are 0, adc_sample is 0, dac_code is 0 and dac_ready is 1.
- R2: The configuration word has mode in bits [3:0], invert in bit [4], partner index in bits [9:5] and range code in bits [12:10]. It is stored for each port whose cfg_we bit is high. With mode 3 the port sets pin_oe and drives its gpo_wdata bit, as last stored with gpo_we.
- R3: With mode 4 the port sets pin_oe and drives the input of its partner port, sampled on the clock edge, XORed with its invert bit.
- R4: Several mode-4 ports that name the same partner all follow that partner's input on the same edge, each applying its own invert bit.
- R5: A mode-4 port drives 0 whenever its partner is not in mode 1 (digital input), whatever the invert bit.
- R6: A mode-4 port whose partner index is NUM_PORTS or more drives 0, whatever the invert bit.
- R7: A dac_we strobe stores dac_wdata and drops dac_ready for exactly SETTLE_CYCLES clock edges. A new strobe during that time restarts the full interval.
- R8: While dac_ready is 0, a port in mode 3 or mode 4 drives 0.
- R9: In mode 6 with range code 100 or 110, dac_code is the stored code limited to CLIP_CODE. In every other case dac_code equals the stored code.
- R10: adc_sample is 1 for a port in mode 6, 7 or 8. It is also 1 for any port named as partner by a mode-8 port with a valid index.
- R11: In any mode other than 3 and 4 (modes 0, 1, 2 and 9 to 15 included), pin_oe and pin_out are 0. Modes 0, 1, 2, 3, 4, 5 and 9 to 15 never raise the port's own adc_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | NUM_PORTS | Per-port configuration write strobe |
| cfg_wdata | input | 13 | Configuration word |
| dac_we | input | NUM_PORTS | Per-port DAC code write strobe |
| dac_wdata | input | DAC_W | DAC code |
| gpo_we | input | 1 | Output data register write strobe |
| gpo_wdata | input | NUM_PORTS | Output data bits, one per port |
| pin_in | input | NUM_PORTS | Digital input level of each port |
| pin_out | output | NUM_PORTS | Digital output level of each port |
| pin_oe | output | NUM_PORTS | Digital output enable of each port |
| dac_code | output | NUM_PORTS*DAC_W | Clipped DAC code of each port, port 0 in the low bits |
| dac_ready | output | NUM_PORTS | Settling interval of each port has expired |
| adc_sample | output | NUM_PORTS | Port must be sampled by the converter |

## Verification
The risky overlap is a DAC rewrite landing in the same cycle that a mirrored source input toggles. The settling restart must then hide the toggle on the rewritten port, while a sibling port on the same source shows it at once. The bench drives both strobes on one edge, partway through an interval that is already running. It then counts edges until dac_ready returns and checks that the rewritten port stays low for the whole restarted interval, while its sibling follows the new input level.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int MODE_W  = 4;
   localparam int IDX_W   = 5;
   localparam int RANGE_W = 3;
   localparam int CFG_W   = RANGE_W + IDX_W + 1 + MODE_W;

   localparam logic [MODE_W-1:0] MODE_DIN      = 4'd1;
   localparam logic [MODE_W-1:0] MODE_DOUT_REG = 4'd3;
   localparam logic [MODE_W-1:0] MODE_DOUT_MIR = 4'd4;
   localparam logic [MODE_W-1:0] MODE_DAC      = 4'd5;
   localparam logic [MODE_W-1:0] MODE_DAC_MON  = 4'd6;
   localparam logic [MODE_W-1:0] MODE_ADC_SE   = 4'd7;
   localparam logic [MODE_W-1:0] MODE_ADC_DIFF = 4'd8;

   localparam logic [RANGE_W-1:0] RNG_HALF_A = 3'b100;
   localparam logic [RANGE_W-1:0] RNG_HALF_B = 3'b110;

   typedef struct packed {
      logic [RANGE_W-1:0] rng;
      logic [IDX_W-1:0]   partner;
      logic               inv;
      logic [MODE_W-1:0]  mode;
   } pmr_cfg_t;

   function automatic logic drives_output(logic [MODE_W-1:0] m);
      return (m == MODE_DOUT_REG) || (m == MODE_DOUT_MIR);
   endfunction

   function automatic logic own_sample(logic [MODE_W-1:0] m);
      return (m == MODE_DAC_MON) || (m == MODE_ADC_SE) || (m == MODE_ADC_DIFF);
   endfunction
endpackage

// File: rtl/pmr_settle.sv
module pmr_settle #(
   parameter int DAC_W         = 12,
   parameter int SETTLE_CYCLES = 250000,
   parameter int CLIP_CODE     = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DAC_W-1:0] code_in,
   input  logic             clip_en,
   output logic [DAC_W-1:0] code_out,
   output logic             ready
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);
   localparam logic [DAC_W-1:0] CLIP_VAL = DAC_W'(CLIP_CODE);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end
   if (CLIP_CODE >= (1 << DAC_W)) begin : g_bad_clip
      $error("CLIP_CODE does not fit in DAC_W bits");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [DAC_W-1:0] raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         raw_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_LOAD;
         raw_q <= code_in;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready    = (cnt_q == '0);
   assign code_out = (clip_en && (raw_q > CLIP_VAL)) ? CLIP_VAL : raw_q;

   // R7
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ready);
   // R7
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !load) |=> ready);
   // R9
   clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clip_en |-> (code_out <= CLIP_VAL));
endmodule

// File: rtl/pmr_mirror.sv
module pmr_mirror #(
   parameter int NUM_PORTS = 20
) (
   input  pmr_pkg::pmr_cfg_t [NUM_PORTS-1:0] cfg,
   input  logic [NUM_PORTS-1:0]              in_q,
   output logic [NUM_PORTS-1:0]              mirror,
   output logic [NUM_PORTS-1:0]              diff_ref
);
   import pmr_pkg::*;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_route
      logic sel_bit;
      logic src_ok;

      always_comb begin
         sel_bit = 1'b0;
         src_ok  = 1'b0;
         for (int j = 0; j < NUM_PORTS; j++) begin
            if (cfg[i].partner == IDX_W'(j)) begin
               sel_bit = in_q[j];
               src_ok  = (cfg[j].mode == MODE_DIN);
            end
         end
      end

      assign mirror[i] = src_ok & (sel_bit ^ cfg[i].inv);

      always_comb begin
         diff_ref[i] = 1'b0;
         for (int k = 0; k < NUM_PORTS; k++) begin
            if ((cfg[k].mode == MODE_ADC_DIFF) && (cfg[k].partner == IDX_W'(i)))
               diff_ref[i] = 1'b1;
         end
      end

      // R6
      always_comb begin
         bad_index_chk: assert ((int'(cfg[i].partner) < NUM_PORTS) || !mirror[i]);
      end
   end
endmodule

// File: rtl/port_mode_router.sv
module port_mode_router #(
   parameter int NUM_PORTS     = 20,
   parameter int DAC_W         = 12,
   parameter int SETTLE_CYCLES = 250000,
   parameter int CLIP_CODE     = 1023,
   parameter bit SYNC_INPUT    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          cfg_we,
   input  logic [pmr_pkg::CFG_W-1:0]     cfg_wdata,
   input  logic [NUM_PORTS-1:0]          dac_we,
   input  logic [DAC_W-1:0]              dac_wdata,
   input  logic                          gpo_we,
   input  logic [NUM_PORTS-1:0]          gpo_wdata,
   input  logic [NUM_PORTS-1:0]          pin_in,
   output logic [NUM_PORTS-1:0]          pin_out,
   output logic [NUM_PORTS-1:0]          pin_oe,
   output logic [NUM_PORTS*DAC_W-1:0]    dac_code,
   output logic [NUM_PORTS-1:0]          dac_ready,
   output logic [NUM_PORTS-1:0]          adc_sample
);
   import pmr_pkg::*;

   if ((NUM_PORTS < 2) || (NUM_PORTS > (1 << IDX_W))) begin : g_bad_ports
      $error("NUM_PORTS must lie between 2 and the partner index range");
   end

   pmr_cfg_t [NUM_PORTS-1:0] cfg_q;
   logic [NUM_PORTS-1:0]     gpo_q;
   logic [NUM_PORTS-1:0]     in_q;
   logic [NUM_PORTS-1:0]     mirror;
   logic [NUM_PORTS-1:0]     diff_ref;

   always_ff @(posedge clk) begin
      if (!rst_n)      gpo_q <= '0;
      else if (gpo_we) gpo_q <= gpo_wdata;
   end

   if (SYNC_INPUT) begin : g_in_reg
      always_ff @(posedge clk) begin
         if (!rst_n) in_q <= '0;
         else        in_q <= pin_in;
      end
   end else begin : g_in_direct
      assign in_q = pin_in;
   end

   pmr_mirror #(.NUM_PORTS(NUM_PORTS)) u_mirror (
      .cfg      (cfg_q),
      .in_q     (in_q),
      .mirror   (mirror),
      .diff_ref (diff_ref)
   );

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic clip_en;
      logic is_listed;

      always_ff @(posedge clk) begin
         if (!rst_n)         cfg_q[i] <= '0;
         else if (cfg_we[i]) cfg_q[i] <= pmr_cfg_t'(cfg_wdata);
      end

      assign clip_en = (cfg_q[i].mode == MODE_DAC_MON) &&
                       ((cfg_q[i].rng == RNG_HALF_A) || (cfg_q[i].rng == RNG_HALF_B));

      pmr_settle #(
         .DAC_W         (DAC_W),
         .SETTLE_CYCLES (SETTLE_CYCLES),
         .CLIP_CODE     (CLIP_CODE)
      ) u_settle (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (dac_we[i]),
         .code_in  (dac_wdata),
         .clip_en  (clip_en),
         .code_out (dac_code[i*DAC_W +: DAC_W]),
         .ready    (dac_ready[i])
      );

      always_comb begin
         pin_oe[i]  = drives_output(cfg_q[i].mode);
         pin_out[i] = 1'b0;
         if (cfg_q[i].mode == MODE_DOUT_REG)
            pin_out[i] = dac_ready[i] & gpo_q[i];
         else if (cfg_q[i].mode == MODE_DOUT_MIR)
            pin_out[i] = dac_ready[i] & mirror[i];
      end

      assign adc_sample[i] = own_sample(cfg_q[i].mode) | diff_ref[i];
      assign is_listed     = drives_output(cfg_q[i].mode);

      // R8
      not_ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_listed && !dac_ready[i]) |-> !pin_out[i]);
      // R11
      idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !is_listed |-> (!pin_oe[i] && !pin_out[i]));
      // R2
      reg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((cfg_q[i].mode == MODE_DOUT_REG) && dac_ready[i]) |-> (pin_out[i] == gpo_q[i]));
   end
endmodule

// File: tb/test_port_mode_router.sv
module test_port_mode_router;
   localparam int N  = 20;
   localparam int DW = 12;
   localparam int ST = 8;
   localparam int CL = 1023;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  cfg_we = '0;
   logic [12:0]   cfg_wdata = '0;
   logic [N-1:0]  dac_we = '0;
   logic [DW-1:0] dac_wdata = '0;
   logic          gpo_we = 1'b0;
   logic [N-1:0]  gpo_wdata = '0;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe, dac_ready, adc_sample;
   logic [N*DW-1:0] dac_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   port_mode_router #(.NUM_PORTS(N), .DAC_W(DW), .SETTLE_CYCLES(ST), .CLIP_CODE(CL))
   i_port_mode_router (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .dac_we(dac_we), .dac_wdata(dac_wdata), .gpo_we(gpo_we), .gpo_wdata(gpo_wdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .dac_code(dac_code),
      .dac_ready(dac_ready), .adc_sample(adc_sample)
   );

   // {cfg[12:0], pin_in[19:0], gpo[19:0], out, oe, adc} for port 5
   localparam logic [55:0] VEC [NV] = '{
      {13'h0003, 20'h00000, 20'h00020, 1'b1, 1'b1, 1'b0}, // R2 gpo high
      {13'h0003, 20'h00000, 20'h00000, 1'b0, 1'b1, 1'b0}, // R2 gpo low
      {13'h0044, 20'h00004, 20'h00000, 1'b1, 1'b1, 1'b0}, // R3 mirror
      {13'h0054, 20'h00004, 20'h00000, 1'b0, 1'b1, 1'b0}, // R3 inverted
      {13'h0074, 20'h00000, 20'h00000, 1'b1, 1'b1, 1'b0}, // R3 inverted low
      {13'h0144, 20'h00400, 20'h00000, 1'b0, 1'b1, 1'b0}, // R5 source not input
      {13'h0334, 20'h00000, 20'h00000, 1'b0, 1'b1, 1'b0}, // R6 bad index
      {13'h0007, 20'h00000, 20'h00020, 1'b0, 1'b0, 1'b1}, // R10 mode 7
      {13'h0006, 20'h00000, 20'h00020, 1'b0, 1'b0, 1'b1}, // R10 mode 6
      {13'h0005, 20'h00000, 20'h00020, 1'b0, 1'b0, 1'b0}, // R11 mode 5
      {13'h0009, 20'h00000, 20'h00020, 1'b0, 1'b0, 1'b0}, // R11 mode 9
      {13'h0000, 20'h00000, 20'h00020, 1'b0, 1'b0, 1'b0}  // R11 mode 0
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      cfg_we = '0;
      dac_we = '0;
      gpo_we = 1'b0;
   endtask

   task automatic set_cfg(int port, logic [12:0] w);
      cfg_we = '0;
      cfg_we[port] = 1'b1;
      cfg_wdata = w;
      tick();
   endtask

   task automatic dac_write(int port, logic [DW-1:0] v);
      dac_we = '0;
      dac_we[port] = 1'b1;
      dac_wdata = v;
      tick();
   endtask

   initial begin
      #(4 * 5000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 oe", 32'(pin_oe), 32'h0);
      check("R1 out", 32'(pin_out), 32'h0);
      check("R1 adc", 32'(adc_sample), 32'h0);
      check("R1 ready", 32'(dac_ready), 32'hFFFFF);
      check("R1 code", 32'(dac_code[5*DW +: DW]), 32'h0);

      // ports 0..3 as digital inputs
      cfg_we = 20'h0000F;
      cfg_wdata = 13'h0001;
      tick();

      for (int v = 0; v < NV; v++) begin
         cfg_we = '0;
         cfg_we[5] = 1'b1;
         cfg_wdata = VEC[v][55:43];
         pin_in = VEC[v][42:23];
         gpo_wdata = VEC[v][22:3];
         gpo_we = 1'b1;
         tick();
         check($sformatf("vector %0d out (R2 R3 R5 R6 R11)", v), 32'(pin_out[5]), 32'(VEC[v][2]));
         check($sformatf("vector %0d oe (R2 R11)", v), 32'(pin_oe[5]), 32'(VEC[v][1]));
         check($sformatf("vector %0d adc (R10 R11)", v), 32'(adc_sample[5]), 32'(VEC[v][0]));
      end

      // R4 fan-out: ports 6 and 7 both take port 1, port 7 inverted
      set_cfg(6, 13'h0024);
      set_cfg(7, 13'h0034);
      pin_in = 20'h00002;
      tick();
      check("R4 port6 high", 32'(pin_out[6]), 32'h1);
      check("R4 port7 inv", 32'(pin_out[7]), 32'h0);
      pin_in = 20'h00000;
      tick();
      check("R4 port6 low", 32'(pin_out[6]), 32'h0);
      check("R4 port7 inv low", 32'(pin_out[7]), 32'h1);

      // R7 R8 settling with a restart colliding with an input toggle
      pin_in = 20'h00002;
      dac_write(6, 12'h5A5);
      check("R7 ready drops", 32'(dac_ready[6]), 32'h0);
      check("R8 out held", 32'(pin_out[6]), 32'h0);
      check("R7 code stored", 32'(dac_code[6*DW +: DW]), 32'h5A5);
      for (int k = 1; k <= 3; k++) begin
         tick();
         check("R7 still settling", 32'(dac_ready[6]), 32'h0);
      end
      pin_in = 20'h00000;
      dac_write(6, 12'h123);
      check("R7 restart", 32'(dac_ready[6]), 32'h0);
      check("R4 sibling follows", 32'(pin_out[7]), 32'h1);
      pin_in = 20'h00002;
      for (int k = 1; k < ST; k++) begin
         tick();
         check("R7 restarted interval", 32'(dac_ready[6]), 32'h0);
         check("R8 gated", 32'(pin_out[6]), 32'h0);
      end
      tick();
      check("R7 ready after interval", 32'(dac_ready[6]), 32'h1);
      check("R8 released", 32'(pin_out[6]), 32'h1);

      // R9 clipping
      set_cfg(8, 13'h1006);
      dac_write(8, 12'hFFF);
      check("R9 range 100 clip", 32'(dac_code[8*DW +: DW]), 32'(CL));
      set_cfg(8, 13'h1806);
      check("R9 range 110 clip", 32'(dac_code[8*DW +: DW]), 32'(CL));
      set_cfg(8, 13'h0806);
      check("R9 range 010 no clip", 32'(dac_code[8*DW +: DW]), 32'hFFF);
      set_cfg(8, 13'h1007);
      check("R9 mode 7 no clip", 32'(dac_code[8*DW +: DW]), 32'hFFF);
      set_cfg(8, 13'h1006);
      dac_write(8, 12'h100);
      check("R9 below clip", 32'(dac_code[8*DW +: DW]), 32'h100);

      // R10 differential partner flag
      set_cfg(9, 13'h0188);
      check("R10 diff own", 32'(adc_sample[9]), 32'h1);
      check("R10 diff partner", 32'(adc_sample[12]), 32'h1);
      check("R10 other port", 32'(adc_sample[11]), 32'h0);
      set_cfg(9, 13'h02C8);
      check("R10 bad index own", 32'(adc_sample[9]), 32'h1);
      check("R10 partner released", 32'(adc_sample[12]), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule